// File: doc/BRIEF.md
# CAN Transmit Buffer Arbiter with Cancellation

This block sits between the host-facing control logic of a CAN controller and its transmit engine. It owns a set of dedicated transmit buffers; for each one it keeps a message identifier and a message marker. The host writes these values, raises transmission requests as a bitmap, and may withdraw requests through a cancel bitmap. Whenever the transmit engine is idle, the block picks the pending buffer with the numerically lowest identifier. It hands that buffer's index, identifier and marker to the engine with a one-cycle start pulse, then waits for a done pulse that carries a success flag.

Three status bitmaps are visible to the host. The pending map shows buffers that still wait to be sent. The sent map shows buffers whose frame left successfully. The cancel-done map shows buffers whose cancellation has finished. A cancel for a buffer that is not on the bus takes effect at once. A cancel for the buffer that is on the bus is recorded and resolved when the engine reports its result: a successful frame counts as sent and as cancelled, and a failed frame is dropped with no retry. Buffers marked as FIFO-managed are not affected by cancel requests.

Top module: `tba_top`

## Requirements
- R1: After synchronous reset, the pending, sent and cancel-done maps are all zero and `tx_start` is low.
- R2: Among pending buffers, the one with the numerically lowest identifier is sent next. When identifiers are equal, the lowest buffer index wins. `tx_id` and `tx_mark` carry that buffer's stored values.
- R3: A new choice is made only while no frame is in flight. `tx_start` is high for exactly one cycle. `tx_idx`, `tx_id` and `tx_mark` hold steady from the start pulse until the done pulse, even if a better buffer is requested meanwhile.
- R4: A cancel bit (bit position = buffer index) for a pending buffer that is not in flight clears its pending bit and sets its cancel-done bit on the next clock edge.
- R5: A cancel for the buffer in flight leaves its pending bit set until the engine's done pulse.
- R6: If a cancelled in-flight frame completes with success, pending clears and both the sent bit and the cancel-done bit are set.
- R7: If a cancelled in-flight frame fails, pending clears, only the cancel-done bit is set, and the buffer is not started again.
- R8: A frame that was not cancelled sets the sent bit and clears pending on success. On failure it stays pending and is arbitrated again.
- R9: A cancel bit for a buffer whose `fifo_mode` bit is 1 is ignored: its pending and cancel-done bits do not change.
- R10: A request bit sets that buffer's pending bit and clears its sent and cancel-done bits. A request takes precedence over a cancel of the same buffer in the same cycle.
- R11: A cancel arriving in the same cycle as the done pulse for that buffer is treated as an in-flight cancel. A cancel for a buffer that is not pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write identifier and marker into buffer `cfg_idx` |
| cfg_idx | input | IW | Buffer index for the configuration write |
| cfg_id | input | ID_W | Message identifier to store |
| cfg_mark | input | MK_W | Message marker to store |
| fifo_mode | input | NB | 1 = buffer is FIFO-managed and immune to cancel |
| req_wr | input | 1 | Apply `req_bits` as new transmission requests |
| req_bits | input | NB | Request bitmap, bit i = buffer i |
| cxl_wr | input | 1 | Apply `cxl_bits` as cancel requests |
| cxl_bits | input | NB | Cancel bitmap, bit i = buffer i |
| tx_start | output | 1 | One-cycle start pulse to the transmit engine |
| tx_idx | output | IW | Buffer index in flight |
| tx_id | output | ID_W | Identifier of the frame in flight |
| tx_mark | output | MK_W | Marker of the frame in flight |
| tx_done | input | 1 | Engine finished the current frame |
| tx_ok | input | 1 | Qualifies `tx_done`: 1 = frame sent successfully |
| buf_pend | output | NB | Pending map |
| buf_sent | output | NB | Sent map |
| buf_cxl_done | output | NB | Cancel-done map |

## Verification
The host cancel and the engine's done pulse can arrive in the same cycle for the same buffer. The bench forces this by driving `cxl_wr` and a failing `tx_done` on one clock edge. It then requires the cancel-done result with no restart, rather than the plain failure path that would leave the buffer pending. A second collision is a cancel that arrives while the arbiter is choosing. It is provoked by cancelling a pending buffer in the idle cycle; the bench checks that the cancelled buffer never receives a start pulse.

// File: rtl/tba_pkg.sv
package tba_pkg;

    localparam int TBA_NB   = 32;
    localparam int TBA_ID_W = 29;
    localparam int TBA_MK_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic valid;
        logic ok;
        logic cxl;
    } fin_evt_t;

endpackage

// File: rtl/tba_store.sv
module tba_store #(
    parameter int NB   = tba_pkg::TBA_NB,
    parameter int ID_W = tba_pkg::TBA_ID_W,
    parameter int MK_W = tba_pkg::TBA_MK_W,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [IW-1:0]             idx,
    input  logic [ID_W-1:0]           id,
    input  logic [MK_W-1:0]           mark,
    output logic [NB-1:0][ID_W-1:0]   ids,
    output logic [NB-1:0][MK_W-1:0]   marks
);

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ids[g]   <= '0;
                marks[g] <= '0;
            end else if (wr && (idx == IW'(g))) begin
                ids[g]   <= id;
                marks[g] <= mark;
            end
        end
    end

endmodule

// File: rtl/tba_pick.sv
module tba_pick #(
    parameter int NB   = tba_pkg::TBA_NB,
    parameter int ID_W = tba_pkg::TBA_ID_W,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0][ID_W-1:0] ids,
    input  logic [NB-1:0]           elig,
    output logic                    found,
    output logic [IW-1:0]           win
);

    logic [ID_W-1:0] best;

    // Strict less-than keeps the earlier (lower) index on equal identifiers.
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < NB; i++) begin
            if (elig[i] && (!found || (ids[i] < best))) begin
                found = 1'b1;
                win   = IW'(i);
                best  = ids[i];
            end
        end
    end

endmodule

// File: rtl/tba_status.sv
module tba_status
    import tba_pkg::*;
#(
    parameter int NB  = tba_pkg::TBA_NB,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] req_set,
    input  logic [NB-1:0] cxl_idle,
    input  fin_evt_t      fin,
    input  logic [IW-1:0] fin_idx,
    output logic [NB-1:0] pend_q,
    output logic [NB-1:0] sent_q,
    output logic [NB-1:0] cdone_q
);

    logic [NB-1:0] pend_d, sent_d, cdone_d, fin_hot;

    assign fin_hot = fin.valid ? (NB'(1) << fin_idx) : '0;

    // Order: engine result, then idle cancels, then new requests (last wins).
    always_comb begin
        pend_d  = pend_q;
        sent_d  = sent_q;
        cdone_d = cdone_q;
        if (fin.ok) begin
            pend_d = pend_d & ~fin_hot;
            sent_d = sent_d | fin_hot;
            if (fin.cxl) cdone_d = cdone_d | fin_hot;
        end else if (fin.cxl) begin
            pend_d  = pend_d & ~fin_hot;
            cdone_d = cdone_d | fin_hot;
        end
        pend_d  = pend_d & ~cxl_idle;
        cdone_d = cdone_d | cxl_idle;
        pend_d  = pend_d | req_set;
        sent_d  = sent_d & ~req_set;
        cdone_d = cdone_d & ~req_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            sent_q  <= '0;
            cdone_q <= '0;
        end else begin
            pend_q  <= pend_d;
            sent_q  <= sent_d;
            cdone_q <= cdone_d;
        end
    end

    AST_CDONE_NOT_PEND: assert property (@(posedge clk) disable iff (rst)
        (cdone_q & pend_q) == '0); // R7
    AST_SENT_NOT_PEND: assert property (@(posedge clk) disable iff (rst)
        (sent_q & pend_q) == '0); // R8
    AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|req_set) |=> ((pend_q & $past(req_set)) == $past(req_set))); // R10

endmodule

// File: rtl/tba_top.sv
module tba_top
    import tba_pkg::*;
#(
    parameter int NB   = tba_pkg::TBA_NB,
    parameter int ID_W = tba_pkg::TBA_ID_W,
    parameter int MK_W = tba_pkg::TBA_MK_W,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [ID_W-1:0] cfg_id,
    input  logic [MK_W-1:0] cfg_mark,
    input  logic [NB-1:0]   fifo_mode,
    input  logic            req_wr,
    input  logic [NB-1:0]   req_bits,
    input  logic            cxl_wr,
    input  logic [NB-1:0]   cxl_bits,
    output logic            tx_start,
    output logic [IW-1:0]   tx_idx,
    output logic [ID_W-1:0] tx_id,
    output logic [MK_W-1:0] tx_mark,
    input  logic            tx_done,
    input  logic            tx_ok,
    output logic [NB-1:0]   buf_pend,
    output logic [NB-1:0]   buf_sent,
    output logic [NB-1:0]   buf_cxl_done
);

    arb_state_e              state_q;
    logic [IW-1:0]           cur_q;
    logic [ID_W-1:0]         cur_id_q;
    logic [MK_W-1:0]         cur_mk_q;
    logic                    start_q;
    logic                    cflag_q;

    logic [NB-1:0][ID_W-1:0] ids;
    logic [NB-1:0][MK_W-1:0] marks;
    logic [NB-1:0]           pend_q, sent_q, cdone_q;
    logic [NB-1:0]           cxl_eff, cxl_idle, req_set, cur_hot, elig;
    logic                    busy, hit_fly, found;
    logic [IW-1:0]           win;
    fin_evt_t                fin;

    assign busy     = (state_q == ST_BUSY);
    assign cur_hot  = busy ? (NB'(1) << cur_q) : '0;
    assign cxl_eff  = cxl_wr ? (cxl_bits & ~fifo_mode) : '0;
    assign req_set  = req_wr ? req_bits : '0;
    assign hit_fly  = |(cxl_eff & cur_hot);
    assign cxl_idle = cxl_eff & pend_q & ~cur_hot;
    assign elig     = pend_q & ~cxl_eff;

    assign fin.valid = busy && tx_done;
    assign fin.ok    = busy && tx_done && tx_ok;
    assign fin.cxl   = busy && tx_done && (cflag_q || hit_fly);

    tba_store #(.NB(NB), .ID_W(ID_W), .MK_W(MK_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .idx   (cfg_idx),
        .id    (cfg_id),
        .mark  (cfg_mark),
        .ids   (ids),
        .marks (marks)
    );

    tba_pick #(.NB(NB), .ID_W(ID_W)) u_pick (
        .ids   (ids),
        .elig  (elig),
        .found (found),
        .win   (win)
    );

    tba_status #(.NB(NB)) u_status (
        .clk      (clk),
        .rst      (rst),
        .req_set  (req_set),
        .cxl_idle (cxl_idle),
        .fin      (fin),
        .fin_idx  (cur_q),
        .pend_q   (pend_q),
        .sent_q   (sent_q),
        .cdone_q  (cdone_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            cur_id_q <= '0;
            cur_mk_q <= '0;
            start_q  <= 1'b0;
            cflag_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (found) begin
                        state_q  <= ST_BUSY;
                        cur_q    <= win;
                        cur_id_q <= ids[win];
                        cur_mk_q <= marks[win];
                        start_q  <= 1'b1;
                        cflag_q  <= 1'b0;
                    end
                end
                ST_BUSY: begin
                    if (tx_done) begin
                        state_q <= ST_IDLE;
                        cflag_q <= 1'b0;
                    end else if (hit_fly) begin
                        cflag_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_start     = start_q;
    assign tx_idx       = cur_q;
    assign tx_id        = cur_id_q;
    assign tx_mark      = cur_mk_q;
    assign buf_pend     = pend_q;
    assign buf_sent     = sent_q;
    assign buf_cxl_done = cdone_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start); // R3
    AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_done) |=> ($stable(tx_idx) && $stable(tx_id) && $stable(tx_mark))); // R3
    AST_FLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        busy |-> buf_pend[tx_idx]); // R5
    AST_START_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> buf_pend[tx_idx]); // R2

endmodule

// File: tb/tba_top_bench.sv
module tba_top_bench;
    import tba_pkg::*;

    localparam int NB   = TBA_NB;
    localparam int ID_W = TBA_ID_W;
    localparam int MK_W = TBA_MK_W;
    localparam int IW   = $clog2(NB);

    typedef struct packed {
        logic [0:3][ID_W-1:0] ids;
        logic [3:0]           mask;
        logic [1:0]           win;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{'{29'd40, 29'd30, 29'd20, 29'd10}, 4'b1111, 2'd3},
        '{'{29'd10, 29'd20, 29'd30, 29'd40}, 4'b1111, 2'd0},
        '{'{29'd15, 29'd15, 29'd30, 29'd40}, 4'b1111, 2'd0},
        '{'{29'd50, 29'd15, 29'd15, 29'd40}, 4'b0110, 2'd1},
        '{'{29'd5,  29'd60, 29'd70, 29'd1 }, 4'b0111, 2'd0},
        '{'{29'h1FFFFFFF, 29'h1FFFFFFF, 29'h1FFFFFFF, 29'h1FFFFFFE}, 4'b1111, 2'd3}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [ID_W-1:0] cfg_id = '0;
    logic [MK_W-1:0] cfg_mark = '0;
    logic [NB-1:0]   fifo_mode = '0;
    logic            req_wr = 1'b0;
    logic [NB-1:0]   req_bits = '0;
    logic            cxl_wr = 1'b0;
    logic [NB-1:0]   cxl_bits = '0;
    logic            tx_done = 1'b0;
    logic            tx_ok = 1'b0;
    logic            tx_start;
    logic [IW-1:0]   tx_idx;
    logic [ID_W-1:0] tx_id;
    logic [MK_W-1:0] tx_mark;
    logic [NB-1:0]   buf_pend, buf_sent, buf_cxl_done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tba_top u_tba_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_id(cfg_id),
        .cfg_mark(cfg_mark), .fifo_mode(fifo_mode), .req_wr(req_wr), .req_bits(req_bits),
        .cxl_wr(cxl_wr), .cxl_bits(cxl_bits), .tx_start(tx_start), .tx_idx(tx_idx),
        .tx_id(tx_id), .tx_mark(tx_mark), .tx_done(tx_done), .tx_ok(tx_ok),
        .buf_pend(buf_pend), .buf_sent(buf_sent), .buf_cxl_done(buf_cxl_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All drive tasks start at a falling edge and return at the falling edge
    // right after the rising edge that consumed the stimulus.
    task automatic cfg(input int idx, input logic [ID_W-1:0] id, input logic [MK_W-1:0] mk);
        cfg_wr = 1'b1; cfg_idx = IW'(idx); cfg_id = id; cfg_mark = mk;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic request(input logic [NB-1:0] bits);
        req_wr = 1'b1; req_bits = bits;
        @(negedge clk);
        req_wr = 1'b0; req_bits = '0;
    endtask

    task automatic cancel(input logic [NB-1:0] bits);
        cxl_wr = 1'b1; cxl_bits = bits;
        @(negedge clk);
        cxl_wr = 1'b0; cxl_bits = '0;
    endtask

    task automatic finish_tx(input logic ok);
        tx_done = 1'b1; tx_ok = ok;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0;
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (tx_start) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle_no_start(input string req, input int n);
        int hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tx_start) hits++;
        end
        chk(req, hits, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pend", buf_pend, 0);
        chk("R1 sent", buf_sent, 0);
        chk("R1 cdone", buf_cxl_done, 0);
        chk("R1 start", tx_start, 0);

        // R2: table of arbitration vectors on buffers 8..11
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) cfg(8 + k, VECS[v].ids[k], MK_W'(8'hA0 + k));
            request(NB'(VECS[v].mask) << 8);
            wait_start(seen);
            chk("R2 start seen", seen, 1);
            chk("R2 winner idx", tx_idx, 8 + VECS[v].win);
            chk("R2 winner id", tx_id, VECS[v].ids[VECS[v].win]);
            chk("R2 winner mark", tx_mark, 8'hA0 + VECS[v].win);
            finish_tx(1'b1);
            for (int r = 1; r < $countones(VECS[v].mask); r++) begin
                wait_start(seen);
                finish_tx(1'b1);
            end
            chk("R8 drained pend", buf_pend, 0);
            chk("R8 sent map", buf_sent[11:8] & VECS[v].mask, VECS[v].mask);
        end

        // R4/R5/R6: idle cancel and in-flight cancel with success
        cfg(1, 29'd5, 8'h11);
        cfg(2, 29'd9, 8'h22);
        request(NB'(32'h6));
        wait_start(seen);
        chk("R2 buf1 first", tx_idx, 1);
        // R3: a lower identifier requested mid-flight does not displace buf1
        cfg(12, 29'd0, 8'h33);
        request(NB'(1) << 12);
        chk("R3 idx held", tx_idx, 1);
        chk("R3 id held", tx_id, 5);
        chk("R3 single pulse", tx_start, 0);
        cancel(NB'(1) << 2);
        chk("R4 pend cleared", buf_pend[2], 0);
        chk("R4 cdone set", buf_cxl_done[2], 1);
        cancel(NB'(1) << 1);
        chk("R5 pend held", buf_pend[1], 1);
        finish_tx(1'b1);
        chk("R6 pend", buf_pend[1], 0);
        chk("R6 sent", buf_sent[1], 1);
        chk("R6 cdone", buf_cxl_done[1], 1);
        wait_start(seen);
        chk("R3 next winner", tx_idx, 12);
        finish_tx(1'b1);

        // R10: new request clears sent and cancel-done
        request(NB'(1) << 1);
        chk("R10 pend", buf_pend[1], 1);
        chk("R10 sent", buf_sent[1], 0);
        chk("R10 cdone", buf_cxl_done[1], 0);
        wait_start(seen);
        finish_tx(1'b1);

        // R7: in-flight cancel, then failure -> no retry
        request(NB'(1) << 2);
        wait_start(seen);
        chk("R7 buf2 start", tx_idx, 2);
        cancel(NB'(1) << 2);
        finish_tx(1'b0);
        chk("R7 pend", buf_pend[2], 0);
        chk("R7 sent", buf_sent[2], 0);
        chk("R7 cdone", buf_cxl_done[2], 1);
        idle_no_start("R7 no retry", 4);

        // R8: uncancelled failure stays pending and is retried
        cfg(3, 29'd7, 8'h44);
        request(NB'(1) << 3);
        wait_start(seen);
        finish_tx(1'b0);
        chk("R8 still pend", buf_pend[3], 1);
        chk("R8 not sent", buf_sent[3], 0);
        wait_start(seen);
        chk("R8 retried", {31'd0, seen}, 1);
        chk("R8 retry idx", tx_idx, 3);
        finish_tx(1'b1);
        chk("R8 sent", buf_sent[3], 1);

        // R9: cancel on FIFO-managed buffer ignored
        fifo_mode = NB'(1) << 4;
        cfg(4, 29'd100, 8'h55);
        cfg(5, 29'd50, 8'h66);
        request(NB'(32'h30));
        wait_start(seen);
        chk("R2 buf5 first", tx_idx, 5);
        cancel(NB'(1) << 4);
        chk("R9 pend kept", buf_pend[4], 1);
        chk("R9 no cdone", buf_cxl_done[4], 0);
        finish_tx(1'b1);
        wait_start(seen);
        chk("R9 buf4 sent later", tx_idx, 4);
        finish_tx(1'b1);
        fifo_mode = '0;

        // R11: cancel coinciding with failed done; cancel of idle buffer
        cfg(6, 29'd3, 8'h77);
        request(NB'(1) << 6);
        wait_start(seen);
        tx_done = 1'b1; tx_ok = 1'b0; cxl_wr = 1'b1; cxl_bits = NB'(1) << 6;
        @(negedge clk);
        tx_done = 1'b0; cxl_wr = 1'b0; cxl_bits = '0;
        chk("R11 pend", buf_pend[6], 0);
        chk("R11 cdone", buf_cxl_done[6], 1);
        chk("R11 sent", buf_sent[6], 0);
        idle_no_start("R11 no retry", 3);
        cancel(NB'(1) << 7);
        chk("R11 idle cancel no effect", buf_cxl_done[7], 0);

        // R10: request and cancel same cycle -> request wins
        req_wr = 1'b1; req_bits = NB'(1) << 9; cxl_wr = 1'b1; cxl_bits = NB'(1) << 9;
        @(negedge clk);
        req_wr = 1'b0; req_bits = '0; cxl_wr = 1'b0; cxl_bits = '0;
        chk("R10 req beats cancel", buf_pend[9], 1);
        chk("R10 cdone cleared", buf_cxl_done[9], 0);

        // R4: cancel in the idle cycle before start -> never started
        @(negedge clk);
        finish_tx(1'b1);
        cfg(13, 29'd2, 8'h88);
        request(NB'(1) << 13);
        cancel(NB'(1) << 13);
        chk("R4 pre-start cancel", buf_cxl_done[13], 1);
        idle_no_start("R4 never started", 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule